// File: doc/BRIEF.md
# Single-Bit Boolean Execution Unit

This execution unit works on single bits of a 32-bit processor's data. It reads one bit from each of two source words at two independent 5-bit positions. It combines the two bits with a Boolean function and writes the outcome back in one of four ways. Plain mode returns a zero-extended flag. Accumulate mode folds the outcome into bit 0 of the old destination. Shift mode pushes the outcome into the bottom of the old destination. Insert mode places a source bit, either copied or inverted, at a chosen position of the first source.

The operands have already been decoded into fields and read from the register file by the surrounding pipeline. The unit accepts one operation per cycle on `in_valid`. It returns the result one clock later with a single-cycle `out_valid`. An unused class or function code gives a zero result and raises `out_error`.

Control is a two-state machine. `ST_IDLE` means no result is pending. `ST_EMIT` means a result is being presented. The transitions are:
- ACCEPT: `ST_IDLE` goes to `ST_EMIT` when `in_valid` is high.
- STREAM: `ST_EMIT` stays in `ST_EMIT` when `in_valid` is high.
- DRAIN: `ST_EMIT` goes to `ST_IDLE` when `in_valid` is low.
- REST: `ST_IDLE` stays in `ST_IDLE` when `in_valid` is low.

Top module: `bitop_exec_unit`

## Requirements
- R1: Operand bit A is bit `pos_a` of `src_a`, and operand bit B is bit `pos_b` of `src_b`. Positions are unsigned and run from 0 to 31, so position 31 selects the most significant bit.
- R2: Class 0 (plain) produces the function of A and B in bit 0 of the result and zeros in bits 31..1. Function codes 0..7 are: AND, A AND NOT B, NOR, OR, NAND, A OR NOT B, XNOR, XOR.
- R3: Class 1 and class 2 (accumulate) compute an inner function with codes 0..3 only (AND, A AND NOT B, NOR, OR). Bit 0 of the result is that inner bit ANDed (class 1) or ORed (class 2) with bit 0 of `dst_old`. Bits 31..1 equal `dst_old[31:1]`.
- R4: Class 3 (shift) returns `dst_old` shifted left by one, with bit 31 discarded. Bit 0 holds the result of any of the eight functions of R2.
- R5: Class 4 (insert) returns `src_a` with bit `pos_a` replaced by B (code 0) or by NOT B (code 1). All other bits are unchanged.
- R6: Class codes 5..7, codes 4..7 in classes 1 and 2, and codes 2..7 in class 4 produce an all-zero result with `out_error` high.
- R7: Each cycle with `in_valid` high yields exactly one cycle of `out_valid` on the next clock. A cycle without `in_valid` yields no `out_valid` on the next clock.
- R8: An active-low `rst_n` asynchronously clears `out_result`, `out_error` and `out_valid`.
- R9: `out_error` is low for every legal class and code combination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation strobe |
| src_a | input | 32 | First source word |
| src_b | input | 32 | Second source word |
| dst_old | input | 32 | Previous destination value |
| pos_a | input | 5 | Bit position in src_a |
| pos_b | input | 5 | Bit position in src_b |
| op_class | input | 3 | Write-back class |
| op_sel | input | 3 | Boolean function code |
| out_valid | output | 1 | Result strobe, one cycle |
| out_result | output | 32 | Registered result |
| out_error | output | 1 | Illegal code flag |

## Verification
The embedded properties compare each result with the operands presented one cycle earlier. They therefore assume that `in_valid` is low while `rst_n` is low, and that operand fields are stable for the cycle in which they are sampled. The stimulus drives every input on the falling clock edge and holds `in_valid` low throughout reset, so both assumptions always hold. Random class and code values deliberately include the illegal ones. The properties guard on `out_error` so that they constrain only legal results.

// File: rtl/bitop_pkg.sv
package bitop_pkg;

    typedef enum logic [2:0] {
        CLS_PLAIN   = 3'd0,
        CLS_ACC_AND = 3'd1,
        CLS_ACC_OR  = 3'd2,
        CLS_SHIFT   = 3'd3,
        CLS_INSERT  = 3'd4
    } op_class_e;

    typedef enum logic [2:0] {
        FN_AND  = 3'd0,
        FN_ANDN = 3'd1,
        FN_NOR  = 3'd2,
        FN_OR   = 3'd3,
        FN_NAND = 3'd4,
        FN_ORN  = 3'd5,
        FN_XNOR = 3'd6,
        FN_XOR  = 3'd7
    } bool_fn_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } state_e;

    localparam int unsigned ACC_FN_LIMIT = 4;
    localparam int unsigned INS_FN_LIMIT = 2;

endpackage

// File: rtl/bitop_extract.sv
module bitop_extract #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned POS_W  = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] word_i,
    input  logic [POS_W-1:0]  pos_i,
    output logic              bit_o
);
    logic [DATA_W-1:0] shifted;

    always_comb begin
        shifted = word_i >> pos_i;
        bit_o   = shifted[0];
    end
endmodule

// File: rtl/bitop_logic.sv
module bitop_logic
    import bitop_pkg::*;
(
    input  logic       a_i,
    input  logic       b_i,
    input  logic [2:0] fn_i,
    output logic       y_o
);
    always_comb begin
        unique case (bool_fn_e'(fn_i))
            FN_AND:  y_o = a_i & b_i;
            FN_ANDN: y_o = a_i & ~b_i;
            FN_NOR:  y_o = ~(a_i | b_i);
            FN_OR:   y_o = a_i | b_i;
            FN_NAND: y_o = ~(a_i & b_i);
            FN_ORN:  y_o = a_i | ~b_i;
            FN_XNOR: y_o = ~(a_i ^ b_i);
            FN_XOR:  y_o = a_i ^ b_i;
            default: y_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/bitop_writeback.sv
module bitop_writeback
    import bitop_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned POS_W  = $clog2(DATA_W)
) (
    input  logic [2:0]        cls_i,
    input  logic [2:0]        fn_i,
    input  logic              fn_bit_i,
    input  logic              b_bit_i,
    input  logic [DATA_W-1:0] src_a_i,
    input  logic [DATA_W-1:0] dst_old_i,
    input  logic [POS_W-1:0]  pos_a_i,
    output logic [DATA_W-1:0] result_o,
    output logic              error_o
);
    logic              ins_bit;
    logic [DATA_W-1:0] inserted;

    assign ins_bit = b_bit_i ^ fn_i[0];

    for (genvar gi = 0; gi < DATA_W; gi++) begin : g_ins
        assign inserted[gi] = (pos_a_i == POS_W'(gi)) ? ins_bit : src_a_i[gi];
    end

    always_comb begin
        result_o = '0;
        error_o  = 1'b0;
        unique case (cls_i)
            CLS_PLAIN: begin
                result_o[0] = fn_bit_i;
            end
            CLS_ACC_AND: begin
                if (32'(fn_i) < ACC_FN_LIMIT) begin
                    result_o    = dst_old_i;
                    result_o[0] = dst_old_i[0] & fn_bit_i;
                end else begin
                    error_o = 1'b1;
                end
            end
            CLS_ACC_OR: begin
                if (32'(fn_i) < ACC_FN_LIMIT) begin
                    result_o    = dst_old_i;
                    result_o[0] = dst_old_i[0] | fn_bit_i;
                end else begin
                    error_o = 1'b1;
                end
            end
            CLS_SHIFT: begin
                result_o = {dst_old_i[DATA_W-2:0], fn_bit_i};
            end
            CLS_INSERT: begin
                if (32'(fn_i) < INS_FN_LIMIT) begin
                    result_o = inserted;
                end else begin
                    error_o = 1'b1;
                end
            end
            default: begin
                error_o = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/bitop_exec_unit.sv
module bitop_exec_unit
    import bitop_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned POS_W  = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    input  logic [DATA_W-1:0] dst_old,
    input  logic [POS_W-1:0]  pos_a,
    input  logic [POS_W-1:0]  pos_b,
    input  logic [2:0]        op_class,
    input  logic [2:0]        op_sel,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_result,
    output logic              out_error
);
    state_e            state_q, state_d;
    logic              bit_a, bit_b, fn_bit;
    logic [DATA_W-1:0] wb_result;
    logic              wb_error;

    bitop_extract #(.DATA_W(DATA_W), .POS_W(POS_W)) u_pick_a (
        .word_i(src_a), .pos_i(pos_a), .bit_o(bit_a)
    );

    bitop_extract #(.DATA_W(DATA_W), .POS_W(POS_W)) u_pick_b (
        .word_i(src_b), .pos_i(pos_b), .bit_o(bit_b)
    );

    bitop_logic u_fn (
        .a_i(bit_a), .b_i(bit_b), .fn_i(op_sel), .y_o(fn_bit)
    );

    bitop_writeback #(.DATA_W(DATA_W), .POS_W(POS_W)) u_wb (
        .cls_i(op_class), .fn_i(op_sel), .fn_bit_i(fn_bit), .b_bit_i(bit_b),
        .src_a_i(src_a), .dst_old_i(dst_old), .pos_a_i(pos_a),
        .result_o(wb_result), .error_o(wb_error)
    );

    // next state: ACCEPT / STREAM on in_valid, DRAIN / REST otherwise
    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = in_valid ? ST_EMIT : ST_IDLE;
            ST_EMIT: state_d = in_valid ? ST_EMIT : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_result <= '0;
            out_error  <= 1'b0;
        end else if (in_valid) begin
            out_result <= wb_result;
            out_error  <= wb_error;
        end
    end

    always_comb begin
        out_valid = (state_q == ST_EMIT);
    end

    p_valid_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_no_spurious_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    p_error_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_error |-> (out_result == '0));

    p_plain_upper_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_error && $past(op_class) == 3'(CLS_PLAIN))
        |-> (out_result[DATA_W-1:1] == '0));

    p_acc_upper_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_error &&
         ($past(op_class) == 3'(CLS_ACC_AND) || $past(op_class) == 3'(CLS_ACC_OR)))
        |-> (out_result[DATA_W-1:1] == $past(dst_old[DATA_W-1:1])));

    p_shift_body_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_error && $past(op_class) == 3'(CLS_SHIFT))
        |-> (out_result[DATA_W-1:1] == $past(dst_old[DATA_W-2:0])));

    p_insert_one_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_error && $past(op_class) == 3'(CLS_INSERT))
        |-> ($countones(out_result ^ $past(src_a)) <= 1));

endmodule

// File: tb/bitop_exec_unit_tb_top.sv
module bitop_exec_unit_tb_top;

    typedef struct {
        logic [31:0] res;
        logic        err;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] src_a = '0, src_b = '0, dst_old = '0;
    logic [4:0]  pos_a = '0, pos_b = '0;
    logic [2:0]  op_class = '0, op_sel = '0;
    logic        out_valid, out_error;
    logic [31:0] out_result;

    int   n_checks = 0;
    int   n_errors = 0;
    bit   finished = 1'b0;
    exp_t sb_q[$];

    always #5 clk = ~clk;

    bitop_exec_unit dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .src_a(src_a), .src_b(src_b), .dst_old(dst_old),
        .pos_a(pos_a), .pos_b(pos_b), .op_class(op_class), .op_sel(op_sel),
        .out_valid(out_valid), .out_result(out_result), .out_error(out_error)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic exp_t model(input logic [2:0] c, input logic [2:0] s,
                                   input logic [31:0] a, input logic [31:0] b,
                                   input logic [31:0] d, input logic [4:0] pa,
                                   input logic [4:0] pb);
        exp_t e;
        logic x, y, f;
        x = a[pa];
        y = b[pb];
        case (s)
            3'd0: f = x & y;
            3'd1: f = x & ~y;
            3'd2: f = ~(x | y);
            3'd3: f = x | y;
            3'd4: f = ~(x & y);
            3'd5: f = x | ~y;
            3'd6: f = ~(x ^ y);
            default: f = x ^ y;
        endcase
        e.res = '0;
        e.err = 1'b0;
        e.tag = "R6";
        if (c == 3'd0) begin
            e.res = {31'b0, f};
            e.tag = "R2";
        end else if ((c == 3'd1 || c == 3'd2) && s < 3'd4) begin
            e.res = d;
            e.res[0] = (c == 3'd1) ? (d[0] & f) : (d[0] | f);
            e.tag = "R3";
        end else if (c == 3'd3) begin
            e.res = {d[30:0], f};
            e.tag = "R4";
        end else if (c == 3'd4 && s < 3'd2) begin
            e.res = a;
            e.res[pa] = (s == 3'd1) ? ~y : y;
            e.tag = "R5";
        end else begin
            e.err = 1'b1;
        end
        return e;
    endfunction

    // driver: present one operation for one cycle and queue its expectation
    task automatic issue(input logic [2:0] c, input logic [2:0] s,
                         input logic [31:0] a, input logic [31:0] b,
                         input logic [31:0] d, input logic [4:0] pa,
                         input logic [4:0] pb, input string tag_over);
        exp_t e;
        e = model(c, s, a, b, d, pa, pb);
        if (tag_over != "") e.tag = tag_over;
        op_class = c; op_sel = s; src_a = a; src_b = b; dst_old = d;
        pos_a = pa; pos_b = pb;
        in_valid = 1'b1;
        sb_q.push_back(e);
        @(negedge clk);
    endtask

    // monitor: compare each presented result against the queue head
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (sb_q.size() == 0) begin
                check("R7 unexpected valid", 32'(out_valid), 32'd0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check(e.tag, out_result, e.res);
                check(e.err ? "R6 error flag" : "R9 error flag", 32'(out_error), 32'(e.err));
            end
        end
    end

    initial begin
        #2_000_000;
        if (!finished) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        #3;
        check("R8 reset valid", 32'(out_valid), 32'd0);
        check("R8 reset result", out_result, 32'd0);
        check("R8 reset error", 32'(out_error), 32'd0);
        #20;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: extreme positions in every class and function
        for (int c = 0; c < 5; c++) begin
            for (int s = 0; s < 8; s++) begin
                issue(3'(c), 3'(s), 32'h8000_0001, 32'h8000_0000, 32'h5555_aaaa, 5'd31, 5'd31, "R1");
                issue(3'(c), 3'(s), 32'h7fff_fffe, 32'h0000_0001, 32'haaaa_5555, 5'd0, 5'd0, "R1");
                issue(3'(c), 3'(s), 32'h8000_0000, 32'h0000_0001, 32'hffff_ffff, 5'd31, 5'd0, "R1");
            end
        end

        // R7: a single operation gives exactly one valid cycle
        in_valid = 1'b0;
        @(negedge clk);
        issue(3'd0, 3'd7, 32'h1, 32'h0, 32'h0, 5'd0, 5'd0, "R7");
        in_valid = 1'b0;
        @(negedge clk);
        check("R7 single pulse", 32'(out_valid), 32'd0);
        @(negedge clk);
        check("R7 idle", 32'(out_valid), 32'd0);

        // random mix, including illegal codes and idle gaps
        for (int i = 0; i < 600; i++) begin
            issue(3'($urandom_range(0, 7)), 3'($urandom_range(0, 7)), $urandom, $urandom,
                  $urandom, 5'($urandom_range(0, 31)), 5'($urandom_range(0, 31)), "");
            if ($urandom_range(0, 9) == 0) begin
                in_valid = 1'b0;
                @(negedge clk);
            end
        end
        in_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R7 queue drained", 32'(sb_q.size()), 32'd0);

        // R8: asynchronous reset clears a nonzero result
        issue(3'd3, 3'd3, 32'h1, 32'h1, 32'hffff_ffff, 5'd0, 5'd0, "R4");
        in_valid = 1'b0;
        rst_n = 1'b0;
        #1;
        check("R8 async clear result", out_result, 32'd0);
        check("R8 async clear valid", 32'(out_valid), 32'd0);
        check("R8 async clear error", 32'(out_error), 32'd0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule